// File: doc/BRIEF.md
# Video Frame Burst Address Generator

This block produces the sequence of memory addresses that a raster display engine needs to pull one field of picture data out of a frame buffer in fixed-size bursts. Software programs two independent geometry sets, each describing the number of lines in a field, the number of bursts per line, the gap (in whole bursts) skipped between the end of one line and the start of the next, and whether one or two frame buffers are in use. Two base-address registers give the start of buffer A and buffer B.

A pulse on `field_go` starts one field. At that moment the block samples `cfg_sel` and the chosen set, picks the buffer, and then walks the field line by line, burst by burst. Each address is offered on a request/acknowledge handshake. A gap of zero gives progressive fetching, and a gap equal to the bursts-per-line value fetches every other stored line, as interlaced display needs. With two buffers in use, successive fields alternate between A and B. A geometry with zero lines or zero bursts per line is refused with an error flag and no fetches.

Top module: `vfetch_addr_gen`

## Requirements
- R1: After reset `burst_req`, `field_sof`, `field_eof` and `cfg_err` are 0 and every register index (0 to 5) reads back 0.
- R2: Register indices are 0 = set 0 control, 1 = set 0 spacing, 2 = set 1 control, 3 = set 1 spacing, 4 = buffer A base, 5 = buffer B base. Control holds the single-buffer flag in bit 0 and the line count in bits 16 and up (LINE_W bits). Spacing holds the bursts per line in bits 0 and up (BPL_W bits) and the gap in bits 16 and up (GAP_W bits). Base holds ADDR_W address bits from bit 0. All other bits, and indices 6 and 7, read 0, and writes to them are ignored.
- R3: A legal field issues exactly lines × bursts-per-line requests. Within a line each address is BURST_BYTES above the previous one, and the first address is the selected buffer base.
- R4: After the last burst of a line, the next address is the last one plus (gap + 1) × BURST_BYTES, so line k starts at base + k × (bursts + gap) × BURST_BYTES.
- R5: While `burst_req` is high and `burst_ack` is low, on the next cycle `burst_req` stays high and `burst_addr` is unchanged.
- R6: `field_sof` pulses for one cycle, in the first cycle the first request of a field is presented. `field_eof` pulses for one cycle, in the cycle after the final acknowledge, with `burst_req` low.
- R7: With the single-buffer flag at 0, successive fields start at A, B, A, and so on. With the flag at 1, the field starts at A, and the next two-buffer field also starts at A.
- R8: `cfg_sel` (0 = set 0, 1 = set 1) and the set contents are sampled only when a field starts. A register write during a field affects only later fields.
- R9: A start with a line count or bursts-per-line value of 0 sets `cfg_err`, and the block issues no request and no `field_sof`. The next legal start clears `cfg_err`.
- R10: A `field_go` pulse while a field is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for writes |
| wr_data | input | 32 | Register write data |
| rd_idx | input | 3 | Register index for reads |
| rd_data | output | 32 | Register read data (combinational) |
| cfg_sel | input | 1 | Geometry set chosen for the next field |
| field_go | input | 1 | Start-of-field command pulse |
| burst_req | output | 1 | Burst fetch request |
| burst_addr | output | ADDR_W | Byte address of the requested burst |
| burst_ack | input | 1 | Burst request accepted |
| field_sof | output | 1 | First burst of a field is on offer |
| field_eof | output | 1 | Last burst of the field was accepted |
| cfg_err | output | 1 | Last start was refused for a zero count |

## Verification
On every cycle the embedded properties check several rules. A pending request keeps its address. The start-of-field strobe appears only together with a request. The end-of-field strobe and the error flag appear only with the request low. The line and burst counters stay inside the latched geometry. A base-register write shows up in the register on the next cycle. Only the bench scenarios can show that the addresses are right. For this, the bench sweeps every small combination of lines, bursts and gap and compares each address with the arithmetic line-start formula. The scenarios also cover A/B alternation across fields, the refusal of zero counts, mid-field writes and ignored restarts, and reserved-bit masking.

// File: rtl/vfag_pkg.sv
package vfag_pkg;
   localparam int IDX_W = 3;
   localparam logic [IDX_W-1:0] IDX_BASE_A = 3'd4;
   localparam logic [IDX_W-1:0] IDX_BASE_B = 3'd5;
   localparam int FIELD_HI_LSB = 16;
   localparam int NUM_SETS = 2;
endpackage

// File: rtl/vfag_regs.sv
module vfag_regs
   import vfag_pkg::*;
#(
   parameter int LINE_W = 10,
   parameter int BPL_W  = 8,
   parameter int GAP_W  = 8,
   parameter int ADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [31:0]        wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [31:0]        rd_data,
   input  logic               cfg_sel,
   output logic               sel_single,
   output logic [LINE_W-1:0]  sel_lines,
   output logic [BPL_W-1:0]   sel_bpl,
   output logic [GAP_W-1:0]   sel_gap,
   output logic [ADDR_W-1:0]  base_a,
   output logic [ADDR_W-1:0]  base_b
);
   logic              single_q [NUM_SETS];
   logic [LINE_W-1:0] lines_q  [NUM_SETS];
   logic [BPL_W-1:0]  bpl_q    [NUM_SETS];
   logic [GAP_W-1:0]  gap_q    [NUM_SETS];
   logic [ADDR_W-1:0] base_a_q, base_b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            single_q[s] <= 1'b0;
            lines_q[s]  <= '0;
            bpl_q[s]    <= '0;
            gap_q[s]    <= '0;
         end
         base_a_q <= '0;
         base_b_q <= '0;
      end else if (wr_en) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            if (wr_idx == IDX_W'(2*s)) begin
               single_q[s] <= wr_data[0];
               lines_q[s]  <= wr_data[FIELD_HI_LSB +: LINE_W];
            end
            if (wr_idx == IDX_W'(2*s+1)) begin
               bpl_q[s] <= wr_data[0 +: BPL_W];
               gap_q[s] <= wr_data[FIELD_HI_LSB +: GAP_W];
            end
         end
         if (wr_idx == IDX_BASE_A) base_a_q <= wr_data[ADDR_W-1:0];
         if (wr_idx == IDX_BASE_B) base_b_q <= wr_data[ADDR_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (rd_idx == IDX_W'(2*s)) begin
            rd_data[0] = single_q[s];
            rd_data[FIELD_HI_LSB +: LINE_W] = lines_q[s];
         end
         if (rd_idx == IDX_W'(2*s+1)) begin
            rd_data[0 +: BPL_W] = bpl_q[s];
            rd_data[FIELD_HI_LSB +: GAP_W] = gap_q[s];
         end
      end
      if (rd_idx == IDX_BASE_A) rd_data[ADDR_W-1:0] = base_a_q;
      if (rd_idx == IDX_BASE_B) rd_data[ADDR_W-1:0] = base_b_q;
   end

   assign sel_single = single_q[cfg_sel];
   assign sel_lines  = lines_q[cfg_sel];
   assign sel_bpl    = bpl_q[cfg_sel];
   assign sel_gap    = gap_q[cfg_sel];
   assign base_a     = base_a_q;
   assign base_b     = base_b_q;

   // R2: a base write lands in the register one cycle later
   p_base_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_BASE_A) |=> (base_a == $past(wr_data[ADDR_W-1:0])));
endmodule

// File: rtl/vfag_walker.sv
module vfag_walker #(
   parameter int LINE_W      = 10,
   parameter int BPL_W       = 8,
   parameter int GAP_W       = 8,
   parameter int ADDR_W      = 32,
   parameter int BURST_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              cfg_single,
   input  logic [LINE_W-1:0] cfg_lines,
   input  logic [BPL_W-1:0]  cfg_bpl,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic [ADDR_W-1:0] base_a,
   input  logic [ADDR_W-1:0] base_b,
   input  logic              ack,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output logic              sof,
   output logic              eof,
   output logic              err
);
   localparam bit IS_POW2 = (BURST_BYTES & (BURST_BYTES - 1)) == 0;
   localparam int SHIFT   = $clog2(BURST_BYTES);
   localparam logic [ADDR_W-1:0] BURST_STEP = ADDR_W'(BURST_BYTES);

   logic              running;
   logic              next_b;
   logic [LINE_W-1:0] lines_q, line_cnt;
   logic [BPL_W-1:0]  bpl_q, burst_cnt;
   logic [GAP_W-1:0]  gap_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] gap_plus1, line_step;
   logic              last_burst, last_line;

   assign gap_plus1 = ADDR_W'(gap_q) + ADDR_W'(1);

   generate
      if (IS_POW2) begin : g_shift_step
         assign line_step = gap_plus1 << SHIFT;
      end else begin : g_mult_step
         assign line_step = gap_plus1 * BURST_STEP;
      end
   endgenerate

   assign last_burst = (burst_cnt == bpl_q - BPL_W'(1));
   assign last_line  = (line_cnt == lines_q - LINE_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running   <= 1'b0;
         next_b    <= 1'b0;
         sof       <= 1'b0;
         eof       <= 1'b0;
         err       <= 1'b0;
         lines_q   <= '0;
         bpl_q     <= '0;
         gap_q     <= '0;
         line_cnt  <= '0;
         burst_cnt <= '0;
         addr_q    <= '0;
      end else begin
         sof <= 1'b0;
         eof <= 1'b0;
         if (!running && go) begin
            if (cfg_lines == '0 || cfg_bpl == '0) begin
               err <= 1'b1;
            end else begin
               err       <= 1'b0;
               running   <= 1'b1;
               sof       <= 1'b1;
               lines_q   <= cfg_lines;
               bpl_q     <= cfg_bpl;
               gap_q     <= cfg_gap;
               line_cnt  <= '0;
               burst_cnt <= '0;
               if (cfg_single) begin
                  addr_q <= base_a;
                  next_b <= 1'b0;
               end else begin
                  addr_q <= next_b ? base_b : base_a;
                  next_b <= ~next_b;
               end
            end
         end else if (running && ack) begin
            if (!last_burst) begin
               burst_cnt <= burst_cnt + BPL_W'(1);
               addr_q    <= addr_q + BURST_STEP;
            end else if (!last_line) begin
               burst_cnt <= '0;
               line_cnt  <= line_cnt + LINE_W'(1);
               addr_q    <= addr_q + line_step;
            end else begin
               running <= 1'b0;
               eof     <= 1'b1;
            end
         end
      end
   end

   assign req  = running;
   assign addr = addr_q;

   // R5: a pending request keeps its address
   p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(addr)));
   // R6: start strobe only with a request on offer
   p_sof_with_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> req);
   // R6: end strobe only once the request has dropped
   p_eof_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> !req);
   // R9: a refused start never fetches
   p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !req);
   // R3: counters stay inside the latched geometry
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (line_cnt < lines_q && burst_cnt < bpl_q));
   // R10: a running field is never restarted
   p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> !sof);
endmodule

// File: rtl/vfetch_addr_gen.sv
module vfetch_addr_gen
   import vfag_pkg::*;
#(
   parameter int LINE_W      = 10,
   parameter int BPL_W       = 8,
   parameter int GAP_W       = 8,
   parameter int ADDR_W      = 32,
   parameter int BURST_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_idx,
   input  logic [31:0]       wr_data,
   input  logic [2:0]        rd_idx,
   output logic [31:0]       rd_data,
   input  logic              cfg_sel,
   input  logic              field_go,
   output logic              burst_req,
   output logic [ADDR_W-1:0] burst_addr,
   input  logic              burst_ack,
   output logic              field_sof,
   output logic              field_eof,
   output logic              cfg_err
);
   generate
      if (LINE_W < 1 || LINE_W > 16) begin : g_bad_line_w
         $error("LINE_W must lie in 1..16");
      end
      if (BPL_W < 1 || BPL_W > 16) begin : g_bad_bpl_w
         $error("BPL_W must lie in 1..16");
      end
      if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap_w
         $error("GAP_W must lie in 1..16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("ADDR_W must lie in 8..32");
      end
      if (BURST_BYTES < 1) begin : g_bad_burst
         $error("BURST_BYTES must be positive");
      end
   endgenerate

   logic              sel_single;
   logic [LINE_W-1:0] sel_lines;
   logic [BPL_W-1:0]  sel_bpl;
   logic [GAP_W-1:0]  sel_gap;
   logic [ADDR_W-1:0] base_a, base_b;

   vfag_regs #(
      .LINE_W(LINE_W), .BPL_W(BPL_W), .GAP_W(GAP_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .cfg_sel(cfg_sel),
      .sel_single(sel_single), .sel_lines(sel_lines),
      .sel_bpl(sel_bpl), .sel_gap(sel_gap),
      .base_a(base_a), .base_b(base_b)
   );

   vfag_walker #(
      .LINE_W(LINE_W), .BPL_W(BPL_W), .GAP_W(GAP_W),
      .ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .go(field_go),
      .cfg_single(sel_single), .cfg_lines(sel_lines),
      .cfg_bpl(sel_bpl), .cfg_gap(sel_gap),
      .base_a(base_a), .base_b(base_b),
      .ack(burst_ack), .req(burst_req), .addr(burst_addr),
      .sof(field_sof), .eof(field_eof), .err(cfg_err)
   );
endmodule

// File: tb/vfetch_addr_gen_bench.sv
module vfetch_addr_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int BB = 16;
   localparam logic [AW-1:0] BASE_A = 16'h1000;
   localparam logic [AW-1:0] BASE_B = 16'h4000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_idx = '0;
   logic [31:0]   wr_data = '0;
   logic [2:0]    rd_idx = '0;
   logic [31:0]   rd_data;
   logic          cfg_sel = 1'b0;
   logic          field_go = 1'b0;
   logic          burst_req;
   logic [AW-1:0] burst_addr;
   logic          burst_ack = 1'b0;
   logic          field_sof, field_eof, cfg_err;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vfetch_addr_gen #(
      .LINE_W(4), .BPL_W(4), .GAP_W(4), .ADDR_W(AW), .BURST_BYTES(BB)
   ) u_vfetch_addr_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .cfg_sel(cfg_sel), .field_go(field_go), .burst_req(burst_req),
      .burst_addr(burst_addr), .burst_ack(burst_ack),
      .field_sof(field_sof), .field_eof(field_eof), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] data);
      wr_en = 1'b1; wr_idx = idx; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string tag);
      rd_idx = idx;
      #1;
      check(rd_data == exp, tag, rd_data, exp);
   endtask

   task automatic set_geom(input int s, input int lines, input int bpl, input int gap, input bit single);
      wr(3'(2*s),   (32'(lines) << 16) | 32'(single));
      wr(3'(2*s+1), (32'(gap) << 16) | 32'(bpl));
   endtask

   // act: 0 none, 1 pulse field_go mid-field (R10), 2 rewrite set 0 spacing mid-field (R8)
   task automatic run_field(input logic [AW-1:0] base, input int lines, input int bpl,
                            input int gap, input int seed, input int act, input logic [31:0] mid_data);
      field_go = 1'b1;
      @(negedge clk);
      field_go = 1'b0;
      check(field_sof && burst_req, "R6 sof with first request", {field_sof, burst_req}, 2'b11);
      for (int l = 0; l < lines; l++) begin
         for (int b = 0; b < bpl; b++) begin
            logic [AW-1:0] exp;
            int w;
            exp = base + AW'((l * (bpl + gap) + b) * BB);
            check(burst_req && burst_addr == exp, (b == 0 && l > 0) ? "R4 line start" : "R3 burst addr",
                  burst_addr, exp);
            w = (l + b + seed) % 3;
            if (l == 0 && b == 0 && act != 0) w = 2;
            for (int d = 0; d < w; d++) begin
               if (d == 0 && act == 1) field_go = 1'b1;
               if (d == 0 && act == 2) begin
                  wr_en = 1'b1; wr_idx = 3'd1; wr_data = mid_data;
               end
               @(negedge clk);
               field_go = 1'b0;
               wr_en = 1'b0;
               check(burst_req && burst_addr == exp && !field_sof, "R5 hold", burst_addr, exp);
            end
            burst_ack = 1'b1;
            @(negedge clk);
            burst_ack = 1'b0;
            if (l == lines - 1 && b == bpl - 1)
               check(field_eof && !burst_req, "R6 eof after last ack", {field_eof, burst_req}, 2'b10);
            else
               check(!field_sof && !field_eof, "R6 no stray strobe", {field_sof, field_eof}, 2'b00);
         end
      end
      @(negedge clk);
      check(!burst_req && !field_eof && !field_sof, "R10 idle after field",
            {burst_req, field_eof, field_sof}, 3'b000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!burst_req && !field_sof && !field_eof && !cfg_err, "R1 outputs idle",
            {burst_req, field_sof, field_eof, cfg_err}, 4'b0000);
      for (int i = 0; i < 6; i++) rd(3'(i), 32'h0, "R1 register reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R2: field masks and reserved bits
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, 32'h000F_0001, "R2 control mask");
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, 32'h000F_000F, "R2 spacing mask");
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, 32'h0000_FFFF, "R2 base mask");
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd6, 32'h0, "R2 unused index");
      rd(3'd7, 32'h0, "R2 unused index");
      wr(3'd2, 32'h0003_0000);
      rd(3'd2, 32'h0003_0000, "R2 set 1 control");
      rd(3'd0, 32'h000F_0001, "R2 set 0 untouched");
      wr(3'd4, 32'(BASE_A));
      wr(3'd5, 32'(BASE_B));
      rd(3'd5, 32'(BASE_B), "R2 base B");

      // R3/R4: sweep geometry, single buffer, set 0
      cfg_sel = 1'b0;
      for (int nl = 1; nl <= 3; nl++)
         for (int nb = 1; nb <= 3; nb++)
            for (int ng = 0; ng <= 3; ng++) begin
               set_geom(0, nl, nb, ng, 1'b1);
               run_field(BASE_A, nl, nb, ng, nl + nb + ng, 0, 32'h0);
            end

      // R7: alternation A, B, A then single-buffer A then double restarts at A
      set_geom(0, 2, 2, 0, 1'b0);
      run_field(BASE_A, 2, 2, 0, 0, 0, 32'h0);
      run_field(BASE_B, 2, 2, 0, 1, 0, 32'h0);
      run_field(BASE_A, 2, 2, 0, 2, 0, 32'h0);
      set_geom(1, 1, 2, 0, 1'b1);
      cfg_sel = 1'b1;
      run_field(BASE_A, 1, 2, 0, 0, 0, 32'h0);
      cfg_sel = 1'b0;
      run_field(BASE_A, 2, 2, 0, 1, 0, 32'h0);
      run_field(BASE_B, 2, 2, 0, 2, 0, 32'h0);

      // R8: set choice, and mid-field write applying only to the next field
      set_geom(0, 2, 2, 2, 1'b1);
      set_geom(1, 1, 3, 0, 1'b1);
      cfg_sel = 1'b1;
      run_field(BASE_A, 1, 3, 0, 0, 0, 32'h0);
      cfg_sel = 1'b0;
      run_field(BASE_A, 2, 2, 2, 0, 2, 32'h0000_0003);
      run_field(BASE_A, 2, 3, 0, 1, 0, 32'h0);

      // R10: field_go while running is ignored
      run_field(BASE_A, 2, 3, 0, 2, 1, 32'h0);

      // R9: zero counts refused
      set_geom(1, 0, 2, 0, 1'b1);
      cfg_sel = 1'b1;
      field_go = 1'b1;
      @(negedge clk);
      field_go = 1'b0;
      check(cfg_err && !burst_req && !field_sof, "R9 zero lines", {cfg_err, burst_req, field_sof}, 3'b100);
      repeat (3) begin
         @(negedge clk);
         check(cfg_err && !burst_req, "R9 stays quiet", {cfg_err, burst_req}, 2'b10);
      end
      set_geom(1, 2, 0, 0, 1'b1);
      field_go = 1'b1;
      @(negedge clk);
      field_go = 1'b0;
      check(cfg_err && !burst_req && !field_sof, "R9 zero bursts", {cfg_err, burst_req, field_sof}, 3'b100);
      set_geom(1, 1, 1, 0, 1'b1);
      run_field(BASE_A, 1, 1, 0, 0, 0, 32'h0);
      check(!cfg_err, "R9 error cleared by legal start", cfg_err, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule